// File: doc/BRIEF.md
# SHA-1 Block Compression Engine (Retimed Round Loop)

This engine applies the SHA-1 compression function to one already padded 512-bit message block. It performs one round per clock. A caller presents the block, the 160-bit chaining value and a single-cycle start pulse. After a fixed latency the engine presents the new chaining value and raises a done pulse for one cycle. Padding and splitting a message into blocks are left to the caller. To hash a longer message, the caller feeds the result of one block back in as the chaining value of the next.

The five-operand sum in each round is split in two. The first half adds Ft, the fifth working word, the expanded message word and the round constant one cycle early. It uses two carry-save adders and keeps the result as a sum/carry pair in a pipeline register. The second half folds ROTL5(A) into that pair with a third carry-save adder and one carry-propagate adder. This takes the message word, the constant and the Boolean function out of the path that feeds A. Before the rounds start, one priming cycle fills the pair register. Sixteen word registers hold the message words and expand them as the rounds run.

Top module: `sha1_retimed_core`

## Requirements
- R1: While reset is asserted and after it is released, before any block completes, `done_o` is 0 and `digest_o` is all zeros.
- R2: With the standard initial chaining value and the padded block of the three-byte message "abc", the digest is a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R3: `done_o` is high for exactly one cycle. It rises on the 82nd rising clock edge after the edge at which start was accepted: one load cycle, one priming cycle and 80 round cycles, with the final addition done at that 82nd edge.
- R4: While a block is in progress, `start_i` has no effect, and changes to `block_i` and `chain_i` have no effect. The running block completes with the values captured at acceptance and at the normal time.
- R5: The chaining value is taken from `chain_i` at acceptance. Each 32-bit word of the digest is that chaining word plus the matching final working word, modulo 2^32. H0 is in bits [159:128] and H4 is in bits [31:0].
- R6: A start presented in the cycle of the done pulse is accepted. Blocks can therefore run back to back, one every 82 cycles.
- R7: Message word 0 is `block_i[511:480]` and word 15 is `block_i[31:0]`.
- R8: `digest_o` holds its value between done pulses.
- R9: The round function and the constant follow the round group: Ch with 5a827999 for rounds 0–19, three-input XOR with 6ed9eba1 for rounds 20–39, majority with 8f1bbcdc for rounds 40–59, and XOR with ca62c1d6 for rounds 60–79. Any block and any chaining value produce the standard SHA-1 compression result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted when idle or in the completion cycle |
| block_i | input | 512 | Padded message block, word 0 in the top bits |
| chain_i | input | 160 | Incoming chaining value, H0 in the top bits |
| digest_o | output | 160 | Updated chaining value |
| done_o | output | 1 | One-cycle pulse when `digest_o` is updated |

## Verification
The checker watches the control sequence on every cycle. It confirms that priming leads into round 0 and that the round index steps by one up to the last round. It also confirms that done lasts one cycle and comes only out of the completion phase, that a start during the rounds is ignored, and that a start in the completion cycle is taken. The digest arithmetic is outside the checker's reach. That covers the Ft and Kt selection, the word expansion, the carry-save split, the word order and the final modular addition. Only the bench's scenarios show these, by comparing against a behavioural model on the "abc" vector, on chained and random blocks, on blocks whose inputs change while busy, and on back-to-back starts.

// File: rtl/sha1_core_pkg.sv
package sha1_core_pkg;

    localparam int WORD_W    = 32;
    localparam int MSG_WORDS = 16;
    localparam int ROUNDS    = 80;
    localparam int GROUP_LEN = 20;
    localparam int BLOCK_W   = WORD_W * MSG_WORDS;
    localparam int STATE_WORDS = 5;
    localparam int STATE_W   = WORD_W * STATE_WORDS;
    localparam int RND_W     = $clog2(ROUNDS + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RND_W-1:0]  rnd_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PRIME = 2'd1,
        PH_ROUND = 2'd2,
        PH_FOLD  = 2'd3
    } phase_e;

    typedef struct packed {
        word_t sum;
        word_t cry;
    } cs_pair_t;

    localparam rnd_t LAST_RND = rnd_t'(ROUNDS - 1);
    localparam rnd_t GRP1_LO  = rnd_t'(GROUP_LEN);
    localparam rnd_t GRP2_LO  = rnd_t'(2 * GROUP_LEN);
    localparam rnd_t GRP3_LO  = rnd_t'(3 * GROUP_LEN);

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (WORD_W - n));
    endfunction

    function automatic word_t round_fn(input rnd_t idx, input word_t x,
                                       input word_t y, input word_t z);
        word_t r;
        if (idx < GRP1_LO)      r = (x & y) | (~x & z);
        else if (idx < GRP2_LO) r = x ^ y ^ z;
        else if (idx < GRP3_LO) r = (x & y) | (x & z) | (y & z);
        else                    r = x ^ y ^ z;
        return r;
    endfunction

    function automatic word_t round_const(input rnd_t idx);
        word_t r;
        if (idx < GRP1_LO)      r = 32'h5a827999;
        else if (idx < GRP2_LO) r = 32'h6ed9eba1;
        else if (idx < GRP3_LO) r = 32'h8f1bbcdc;
        else                    r = 32'hca62c1d6;
        return r;
    endfunction

endpackage

// File: rtl/sha1_csa.sv
module sha1_csa #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] cry_o
);
    logic [W-1:0] maj;

    assign maj   = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    assign sum_o = x_i ^ y_i ^ z_i;
    // carry weight is one bit higher; the top carry drops out modulo 2^W
    assign cry_o = {maj[W-2:0], 1'b0};
endmodule

// File: rtl/sha1_msg_sched.sv
module sha1_msg_sched #(
    parameter int W = 32,
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [N*W-1:0] block_i,
    output logic [W-1:0] w_o
);
    localparam int TAP_A = N - 3;
    localparam int TAP_B = N - 8;
    localparam int TAP_C = N - 14;

    logic [N-1:0][W-1:0] win_d, win_q;
    logic [W-1:0] mix, fresh;

    assign mix   = win_q[TAP_A] ^ win_q[TAP_B] ^ win_q[TAP_C] ^ win_q[0];
    assign fresh = {mix[W-2:0], mix[W-1]};
    assign w_o   = win_q[0];

    for (genvar g = 0; g < N; g++) begin : g_word
        logic [W-1:0] upper;
        if (g == N - 1) begin : g_top
            assign upper = fresh;
        end else begin : g_mid
            assign upper = win_q[g+1];
        end
        assign win_d[g] = load_i  ? block_i[(N-1-g)*W +: W] :
                          shift_i ? upper : win_q[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/sha1_tsum_gen.sv
module sha1_tsum_gen
    import sha1_core_pkg::*;
(
    input  word_t    b_i,
    input  word_t    c_i,
    input  word_t    d_i,
    input  word_t    e_i,
    input  word_t    w_i,
    input  rnd_t     rnd_i,
    output cs_pair_t t_o
);
    word_t f_val, k_val, s0, c0, s1, c1;

    assign f_val = round_fn(rnd_i, b_i, c_i, d_i);
    assign k_val = round_const(rnd_i);

    sha1_csa #(.W(WORD_W)) u_csa_lo (
        .x_i(f_val), .y_i(e_i), .z_i(w_i), .sum_o(s0), .cry_o(c0)
    );
    sha1_csa #(.W(WORD_W)) u_csa_hi (
        .x_i(s0), .y_i(c0), .z_i(k_val), .sum_o(s1), .cry_o(c1)
    );

    assign t_o.sum = s1;
    assign t_o.cry = c1;
endmodule

// File: rtl/sha1_retimed_core.sv
module sha1_retimed_core
    import sha1_core_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [511:0] block_i,
    input  logic [159:0] chain_i,
    output logic [159:0] digest_o,
    output logic         done_o
);
    typedef struct packed {
        phase_e             ph;
        rnd_t               rnd;
        word_t              a;
        word_t              b;
        word_t              c;
        word_t              d;
        word_t              e;
        cs_pair_t           t;
        logic [STATE_W-1:0] hsave;
        logic [STATE_W-1:0] dig;
        logic               done;
    } core_t;

    core_t cq, cd;

    logic     accept, sched_shift;
    word_t    w_cur;
    word_t    tb_b, tb_c, tb_d, tb_e;
    rnd_t     tb_rnd;
    cs_pair_t t_next;
    word_t    a_s, a_c, a_next;
    logic [STATE_W-1:0] work;

    assign accept      = start_i && (cq.ph == PH_IDLE || cq.ph == PH_FOLD);
    assign sched_shift = (cq.ph == PH_PRIME) || (cq.ph == PH_ROUND);

    sha1_msg_sched #(.W(WORD_W), .N(MSG_WORDS)) u_sched (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .shift_i(sched_shift),
        .block_i(block_i), .w_o(w_cur)
    );

    // operands for the partial sum of the round that follows the current one
    always_comb begin
        if (cq.ph == PH_PRIME) begin
            tb_b   = cq.b;
            tb_c   = cq.c;
            tb_d   = cq.d;
            tb_e   = cq.e;
            tb_rnd = '0;
        end else begin
            tb_b   = cq.a;
            tb_c   = rotl(cq.b, 30);
            tb_d   = cq.c;
            tb_e   = cq.d;
            tb_rnd = cq.rnd + rnd_t'(1);
        end
    end

    sha1_tsum_gen u_tsum (
        .b_i(tb_b), .c_i(tb_c), .d_i(tb_d), .e_i(tb_e), .w_i(w_cur),
        .rnd_i(tb_rnd), .t_o(t_next)
    );

    // loop half: ROTL5(A) folded into the stored carry-save pair
    sha1_csa #(.W(WORD_W)) u_csa_a (
        .x_i(rotl(cq.a, 5)), .y_i(cq.t.sum), .z_i(cq.t.cry),
        .sum_o(a_s), .cry_o(a_c)
    );
    assign a_next = a_s + a_c;
    assign work   = {cq.a, cq.b, cq.c, cq.d, cq.e};

    always_comb begin
        cd      = cq;
        cd.done = 1'b0;
        unique case (cq.ph)
            PH_IDLE: ;
            PH_PRIME: begin
                cd.t   = t_next;
                cd.rnd = '0;
                cd.ph  = PH_ROUND;
            end
            PH_ROUND: begin
                cd.a   = a_next;
                cd.b   = cq.a;
                cd.c   = rotl(cq.b, 30);
                cd.d   = cq.c;
                cd.e   = cq.d;
                cd.t   = t_next;
                cd.rnd = cq.rnd + rnd_t'(1);
                if (cq.rnd == LAST_RND) cd.ph = PH_FOLD;
            end
            PH_FOLD: begin
                for (int i = 0; i < STATE_WORDS; i++) begin
                    cd.dig[i*WORD_W +: WORD_W] =
                        cq.hsave[i*WORD_W +: WORD_W] + work[i*WORD_W +: WORD_W];
                end
                cd.done = 1'b1;
                cd.ph   = PH_IDLE;
            end
            default: cd.ph = PH_IDLE;
        endcase
        if (accept) begin
            {cd.a, cd.b, cd.c, cd.d, cd.e} = chain_i;
            cd.hsave = chain_i;
            cd.ph    = PH_PRIME;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cq <= '0;
        else        cq <= cd;
    end

    assign digest_o = cq.dig;
    assign done_o   = cq.done;
endmodule

// File: rtl/sha1_core_chk.sv
module sha1_core_chk
    import sha1_core_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         done_o,
    input logic [159:0] digest_o,
    input logic [1:0]   ph,
    input rnd_t         rnd
);
    // R3
    prime_to_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph == PH_PRIME |=> ph == PH_ROUND && rnd == '0);

    // R3
    round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_ROUND && rnd != LAST_RND) |=>
            (ph == PH_ROUND && rnd == $past(rnd) + rnd_t'(1)));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(ph) == PH_FOLD);

    // R8
    digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(digest_o));

    // R4
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph == PH_PRIME || ph == PH_ROUND) && start_i) |=> ph != PH_PRIME);

    // R6
    fold_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_FOLD && start_i) |=> (ph == PH_PRIME && done_o));
endmodule

bind sha1_retimed_core sha1_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .digest_o(digest_o), .ph(cq.ph), .rnd(cq.rnd)
);

// File: tb/tb_sha1_retimed_core.sv
module tb_sha1_retimed_core;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [511:0] block_i = '0;
    logic [159:0] chain_i = '0;
    logic [159:0] digest_o;
    logic         done_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    localparam logic [159:0] IV      = 160'h67452301_efcdab89_98badcfe_10325476_c3d2e1f0;
    localparam logic [159:0] ABC_DIG = 160'ha9993e36_4706816a_ba3e2571_7850c26c_9cd0d89d;

    sha1_retimed_core dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .block_i(block_i),
        .chain_i(chain_i), .digest_o(digest_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    function automatic logic [159:0] sha1_ref(input logic [511:0] m, input logic [159:0] h);
        logic [31:0] w [80];
        logic [31:0] a, b, c, d, e, f, k, tmp;
        for (int i = 0; i < 16; i++) w[i] = m[511-32*i -: 32];
        for (int i = 16; i < 80; i++) begin
            tmp  = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
            w[i] = {tmp[30:0], tmp[31]};
        end
        {a, b, c, d, e} = h;
        for (int i = 0; i < 80; i++) begin
            if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5a827999; end
            else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ed9eba1; end
            else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8f1bbcdc; end
            else             begin f = b ^ c ^ d;                   k = 32'hca62c1d6; end
            tmp = {a[26:0], a[31:27]} + f + e + k + w[i];
            e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = tmp;
        end
        return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
    endfunction

    function automatic logic [511:0] rand_block();
        logic [511:0] r;
        for (int i = 0; i < 16; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [159:0] rand_chain();
        logic [159:0] r;
        for (int i = 0; i < 5; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    // behavioural reference: a countdown per accepted block
    int           rem = 0;
    logic         exp_done = 1'b0;
    logic [159:0] exp_dig = '0;
    logic [159:0] pend_dig = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            rem = 0; exp_done = 1'b0; exp_dig = '0;
        end else begin
            exp_done = 1'b0;
            if (rem > 0) begin
                rem = rem - 1;
                if (rem == 0) begin
                    exp_done = 1'b1;
                    exp_dig  = pend_dig;
                end
            end
            if (start_i && rem == 0) begin
                rem      = 82;
                pend_dig = sha1_ref(block_i, chain_i);
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (done_o !== exp_done) begin
                errors++;
                $display("FAIL %s (R3 timing): done_o=%0b expected %0b", cur_req, done_o, exp_done);
            end
            checks++;
            if (digest_o !== exp_dig) begin
                errors++;
                $display("FAIL %s (R8 digest): digest_o=%h expected %h", cur_req, digest_o, exp_dig);
            end
        end
    end

    task automatic check_val(input string tag, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [511:0] m, input logic [159:0] h);
        @(negedge clk);
        start_i = 1'b1; block_i = m; chain_i = h;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    logic [511:0] abc_blk;

    initial begin
        abc_blk = '0;
        abc_blk[511:480] = 32'h61626380;   // R7: word 0 in the top bits
        abc_blk[31:0]    = 32'h00000018;

        // R1: reset state
        idle(3);
        check_val("R1 done during reset", {159'd0, done_o}, '0);
        check_val("R1 digest during reset", digest_o, '0);
        rst_n = 1'b1;
        idle(2);
        check_val("R1 digest after reset", digest_o, '0);
        check_val("R1 done after reset", {159'd0, done_o}, '0);

        // R2 / R3 / R7: known vector, latency checked each cycle
        cur_req = "R2";
        pulse_start(abc_blk, IV);
        idle(90);
        check_val("R2 abc digest", digest_o, ABC_DIG);

        // R5: chain from previous digest
        cur_req = "R5";
        begin
            logic [511:0] m2;
            m2 = rand_block();
            pulse_start(m2, digest_o);
            idle(90);
            check_val("R5 chained digest", digest_o, sha1_ref(m2, ABC_DIG));
        end

        // R4: start pulses and input changes during the rounds are ignored
        cur_req = "R4";
        begin
            logic [511:0] m3;
            logic [159:0] h3;
            m3 = rand_block(); h3 = rand_chain();
            pulse_start(m3, h3);
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                block_i = rand_block(); chain_i = rand_chain();
                start_i = (i % 7 == 0);
            end
            @(negedge clk); start_i = 1'b0;
            idle(50);
            check_val("R4 busy inputs ignored", digest_o, sha1_ref(m3, h3));
        end

        // R6: start held high, blocks accepted back to back, inputs churning
        cur_req = "R6";
        @(negedge clk);
        start_i = 1'b1;
        for (int i = 0; i < 200; i++) begin
            block_i = rand_block(); chain_i = rand_chain();
            @(negedge clk);
        end
        start_i = 1'b0;
        idle(90);

        // R9: random blocks and chaining values across all round groups
        cur_req = "R9";
        for (int n = 0; n < 4; n++) begin
            logic [511:0] mr;
            logic [159:0] hr;
            mr = rand_block(); hr = rand_chain();
            pulse_start(mr, hr);
            idle(85);
            check_val("R9 random block", digest_o, sha1_ref(mr, hr));
        end

        // R3: done has returned low and stays low while idle
        idle(5);
        check_val("R3 done idle low", {159'd0, done_o}, '0);

        finish_run();
    end
endmodule